// File: doc/BRIEF.md
# Interprocessor Interrupt Target Resolver

This block turns an interprocessor interrupt command into the set of agents that must receive it. Software first writes the high command word, which carries the 8-bit destination, and then the low command word, which carries the vector, the delivery mode, the destination mode and a shorthand. The write to the low word starts resolution. The block compares the command with a table of agents given at its inputs. Each agent has a physical ID, a logical ID, a flat-or-cluster logical format flag and a ready flag.

For most delivery modes, every matching ready agent is marked in the target mask. For lowest-priority delivery, the matching agents are gathered first. Exactly one of them is then chosen by a round-robin pointer, and there is a separate pointer for each of the 256 vectors. The mask and a one-cycle done strobe appear in the cycle after the low-word write. The low word reads back with its delivery-status bit cleared, because dispatch finishes at once.

Top module: `ipi_dest_resolver`

## Requirements
- R1: Low-word fields are vector [7:0], delivery mode [10:8] (1 = lowest priority, any other value = deliver to all matches), destination mode [11] (0 physical, 1 logical), status [12] and shorthand [19:18]. `done` is high for exactly the one cycle after each low-word write. A high-word write by itself leaves `done` low and the mask unchanged.
- R2: `cmd_lo_rdata` returns the last low word written, with bit 12 forced to 0 and every other bit kept.
- R3: The destination is latched from `cmd_hi_dest` (bits [31:24] of the high command word) when the high word is written. A low-word write resolves against the value latched in earlier cycles.
- R4: Shorthand 0 with physical destination mode matches an agent when its physical ID equals the destination.
- R5: Shorthand 0 with logical mode, for an agent whose format flag is 0 (flat), matches when the AND of its logical ID and the destination is nonzero.
- R6: Shorthand 0 with logical mode, for an agent whose format flag is 1 (cluster), matches when the upper nibbles are equal and the lower nibbles share at least one set bit.
- R7: Shorthand 1 targets only the sender, shorthand 2 targets all agents, and shorthand 3 targets all agents except the sender. In each case the destination is ignored.
- R8: An agent whose ready flag is 0 is never set in the target mask.
- R9: Lowest-priority delivery in logical mode with at least one match sets exactly one bit. The search starts at the agent after the one last chosen for that vector and wraps at the agent count. The result becomes that vector's pointer. Every pointer resets to agent 0.
- R10: Lowest-priority delivery in physical mode, or with no matching agent, yields an empty mask and leaves the vector's pointer unchanged.
- R11: After reset the mask, `done`, the read-back word and the destination are 0. The mask holds its value until the next low-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_lo_wr | input | 1 | Write strobe for the low command word; starts resolution |
| cmd_lo_wdata | input | 32 | Low command word |
| cmd_hi_wr | input | 1 | Write strobe for the high command word |
| cmd_hi_dest | input | 8 | Destination byte of the high command word |
| sender_id | input | IDX_W | Index of the agent issuing the command |
| agent_pid | input | 8*N_AGENTS | Physical IDs, agent g in bits [8g+7:8g] |
| agent_lid | input | 8*N_AGENTS | Logical IDs, same packing |
| agent_cluster | input | N_AGENTS | Logical format per agent: 1 cluster, 0 flat |
| agent_ready | input | N_AGENTS | Agent initialized and enabled |
| cmd_lo_rdata | output | 32 | Read-back of the low word, status bit cleared |
| dest_q | output | 8 | Latched destination |
| target_mask | output | N_AGENTS | Resolved delivery mask |
| done | output | 1 | One-cycle resolution strobe |

## Verification
All results are registered once: `done`, `target_mask` and `cmd_lo_rdata` change at the first rising edge after the low-word write is presented. `dest_q` changes at the edge after the high-word write. The bench drives inputs on falling edges and samples at the falling edge that follows the capturing rising edge. It then samples again one cycle later to see `done` drop and the mask hold. The round-robin expectation is carried forward in the bench's own per-vector pointer table, which is updated only when a lowest-priority command picks an agent.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CMD_W      = 32;
  localparam int VEC_W      = 8;
  localparam int NVEC       = 1 << VEC_W;
  localparam int MODE_LSB   = 8;
  localparam int DMODE_BIT  = 11;
  localparam int STATUS_BIT = 12;
  localparam int SH_LSB     = 18;
  localparam logic [2:0] MODE_LOWEST = 3'd1;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [VEC_W-1:0] vector;
    logic [2:0]       mode;
    logic             logical;
    shorthand_e       sh;
  } ipi_cmd_t;

  function automatic ipi_cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
    ipi_cmd_t c;
    c.vector  = w[VEC_W-1:0];
    c.mode    = w[MODE_LSB +: 3];
    c.logical = w[DMODE_BIT];
    c.sh      = shorthand_e'(w[SH_LSB +: 2]);
    return c;
  endfunction

  // destination-field match for one agent
  function automatic logic addr_match(input logic [7:0] pid, input logic [7:0] lid,
                                      input logic [7:0] dest, input logic logical,
                                      input logic cluster);
    if (!logical) return pid == dest;
    if (!cluster) return (lid & dest) != 8'h00;
    return (lid[7:4] == dest[7:4]) && ((lid[3:0] & dest[3:0]) != 4'h0);
  endfunction
endpackage

// File: rtl/ipi_match.sv
module ipi_match
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = $clog2(N_AGENTS)
) (
  input  ipi_cmd_t              cmd,
  input  logic [7:0]            dest,
  input  logic [IDX_W-1:0]      sender,
  input  logic [8*N_AGENTS-1:0] pid,
  input  logic [8*N_AGENTS-1:0] lid,
  input  logic [N_AGENTS-1:0]   cluster,
  input  logic [N_AGENTS-1:0]   ready,
  output logic [N_AGENTS-1:0]   match
);
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    logic hit;
    always_comb begin
      unique case (cmd.sh)
        SH_NONE:   hit = addr_match(pid[8*g +: 8], lid[8*g +: 8], dest,
                                    cmd.logical, cluster[g]);
        SH_SELF:   hit = (sender == IDX_W'(g));
        SH_ALL:    hit = 1'b1;
        SH_OTHERS: hit = (sender != IDX_W'(g));
        default:   hit = 1'b0;
      endcase
    end
    assign match[g] = hit & ready[g];
  end
endmodule

// File: rtl/ipi_rr_table.sv
module ipi_rr_table
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = $clog2(N_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VEC_W-1:0]      vec,
  input  logic [N_AGENTS-1:0]   cand,
  input  logic                  update,
  output logic [N_AGENTS-1:0]   pick,
  output logic                  found
);
  logic [IDX_W-1:0] ptr_q [NVEC];
  logic [IDX_W-1:0] start, pick_idx;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] base, input int k);
    return IDX_W'((int'(base) + k) % N_AGENTS);
  endfunction

  assign start = ptr_q[vec];

  always_comb begin
    found    = 1'b0;
    pick_idx = start;
    for (int k = 1; k <= N_AGENTS; k++) begin
      if (!found && cand[step(start, k)]) begin
        found    = 1'b1;
        pick_idx = step(start, k);
      end
    end
  end

  assign pick = found ? (N_AGENTS'(1) << pick_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NVEC; v++) ptr_q[v] <= '0;
    end else if (update && found) begin
      ptr_q[vec] <= pick_idx;
    end
  end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 4,
  localparam int IDX_W   = $clog2(N_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_lo_wr,
  input  logic [CMD_W-1:0]      cmd_lo_wdata,
  input  logic                  cmd_hi_wr,
  input  logic [7:0]            cmd_hi_dest,
  input  logic [IDX_W-1:0]      sender_id,
  input  logic [8*N_AGENTS-1:0] agent_pid,
  input  logic [8*N_AGENTS-1:0] agent_lid,
  input  logic [N_AGENTS-1:0]   agent_cluster,
  input  logic [N_AGENTS-1:0]   agent_ready,
  output logic [CMD_W-1:0]      cmd_lo_rdata,
  output logic [7:0]            dest_q,
  output logic [N_AGENTS-1:0]   target_mask,
  output logic                  done
);
  ipi_cmd_t              cmd_now;
  logic [N_AGENTS-1:0]   match_vec, rr_pick, next_mask;
  logic                  is_lowest, lp_allowed, rr_found, rr_update;
  logic                  res_lowest;

  assign cmd_now    = unpack_cmd(cmd_lo_wdata);
  assign is_lowest  = (cmd_now.mode == MODE_LOWEST);
  assign lp_allowed = is_lowest && cmd_now.logical;
  assign rr_update  = cmd_lo_wr && lp_allowed;

  ipi_match #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_match (
    .cmd(cmd_now), .dest(dest_q), .sender(sender_id),
    .pid(agent_pid), .lid(agent_lid), .cluster(agent_cluster),
    .ready(agent_ready), .match(match_vec)
  );

  ipi_rr_table #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .vec(cmd_now.vector), .cand(match_vec),
    .update(rr_update), .pick(rr_pick), .found(rr_found)
  );

  always_comb begin
    if (!is_lowest)       next_mask = match_vec;
    else if (lp_allowed)  next_mask = rr_pick;
    else                  next_mask = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q       <= '0;
      cmd_lo_rdata <= '0;
      target_mask  <= '0;
      done         <= 1'b0;
      res_lowest   <= 1'b0;
    end else begin
      done <= cmd_lo_wr;
      if (cmd_hi_wr) dest_q <= cmd_hi_dest;
      if (cmd_lo_wr) begin
        cmd_lo_rdata             <= cmd_lo_wdata;
        cmd_lo_rdata[STATUS_BIT] <= 1'b0;
        target_mask              <= next_mask;
        res_lowest               <= is_lowest;
      end
    end
  end
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_lo_wr,
  input logic [2:0]          lo_mode,
  input logic                lo_logical,
  input logic [1:0]          lo_sh,
  input logic [IDX_W-1:0]    sender_id,
  input logic [N_AGENTS-1:0] agent_ready,
  input logic                status_rd,
  input logic [N_AGENTS-1:0] target_mask,
  input logic                done,
  input logic                res_lowest,
  input logic                rr_found,
  input logic                rr_update
);
  a_r1_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_wr |=> done);
  a_r1_done_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo_wr |=> !done);
  a_r2_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd);
  a_r7_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_wr && lo_sh == 2'd1) |=>
      ((target_mask & ~(N_AGENTS'(1) << $past(sender_id))) == '0));
  a_r8_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((target_mask & ~$past(agent_ready)) == '0));
  a_r9_lowest_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_lowest) |-> $onehot0(target_mask));
  a_r9_pick_when_found: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_update && rr_found) |=> $countones(target_mask) == 1);
  a_r10_physical_lowest_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_wr && lo_mode == 3'd1 && !lo_logical) |=> (target_mask == '0));
  a_r11_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo_wr |=> $stable(target_mask));
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_lo_wr(cmd_lo_wr),
  .lo_mode(cmd_lo_wdata[10:8]), .lo_logical(cmd_lo_wdata[11]), .lo_sh(cmd_lo_wdata[19:18]),
  .sender_id(sender_id), .agent_ready(agent_ready), .status_rd(cmd_lo_rdata[12]),
  .target_mask(target_mask), .done(done), .res_lowest(res_lowest),
  .rr_found(rr_found), .rr_update(rr_update)
);

// File: tb/ipi_dest_resolver_test.sv
module ipi_dest_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_lo_wr = 1'b0;
  logic [31:0] cmd_lo_wdata = '0;
  logic        cmd_hi_wr = 1'b0;
  logic [7:0]  cmd_hi_dest = '0;
  logic [1:0]  sender_id = '0;
  logic [8*N-1:0] agent_pid = '0, agent_lid = '0;
  logic [N-1:0] agent_cluster = '0, agent_ready = '0;
  logic [31:0] cmd_lo_rdata;
  logic [7:0]  dest_q;
  logic [N-1:0] target_mask;
  logic        done;

  int checks = 0, fails = 0;
  int rr [256];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dest_resolver #(.N_AGENTS(N)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // independent reference: physical, flat, cluster, shorthands, lowest priority
  function automatic logic [N-1:0] model(input logic [31:0] lo, input logic [7:0] d, input int snd);
    logic [N-1:0] m = '0;
    int sh = int'(lo[19:18]);
    int vec = int'(lo[7:0]);
    for (int a = 0; a < N; a++) begin
      int p = int'(agent_pid[8*a +: 8]);
      int l = int'(agent_lid[8*a +: 8]);
      int dd = int'(d);
      bit h;
      if (sh == 1) h = (a == snd);
      else if (sh == 2) h = 1;
      else if (sh == 3) h = (a != snd);
      else if (!lo[11]) h = (p == dd);
      else if (!agent_cluster[a]) h = ((l & dd) != 0);
      else h = ((l / 16) == (dd / 16)) && (((l % 16) & (dd % 16)) != 0);
      m[a] = h && agent_ready[a];
    end
    if (lo[10:8] == 3'd1) begin
      if (!lo[11] || m == '0) return '0;
      for (int k = 1; k <= N; k++) begin
        int idx = (rr[vec] + k) % N;
        if (m[idx]) begin
          rr[vec] = idx;
          return N'(1) << idx;
        end
      end
    end
    return m;
  endfunction

  task automatic issue(input string req, input logic [31:0] lo, input logic [7:0] d, input int snd);
    logic [N-1:0] exp;
    @(negedge clk);
    cmd_hi_wr = 1; cmd_hi_dest = d;
    @(negedge clk);
    cmd_hi_wr = 0;
    chk({req, " R3 dest latch"}, 32'(dest_q), 32'(d));
    cmd_lo_wr = 1; cmd_lo_wdata = lo; sender_id = 2'(snd);
    exp = model(lo, d, snd);
    @(negedge clk);
    cmd_lo_wr = 0;
    chk({req, " R1 done"}, 32'(done), 32'd1);
    chk(req, 32'(target_mask), 32'(exp));
    chk("R2 readback", cmd_lo_rdata, lo & ~32'h1000);
    @(negedge clk);
    chk("R1 done drops", 32'(done), 32'd0);
    chk("R11 mask holds", 32'(target_mask), 32'(exp));
  endtask

  function automatic string tag_of(input logic [31:0] lo, input logic [N-1:0] cl);
    if (lo[10:8] == 3'd1) return lo[11] ? "R9 lowest" : "R10 lowest physical";
    if (lo[19:18] != 2'd0) return "R7 shorthand";
    if (!lo[11]) return "R4 physical";
    return (cl != '0) ? "R6 cluster" : "R5 flat";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    logic [7:0] dests [8] = '{8'h01, 8'h04, 8'h0A, 8'h03, 8'h0F, 8'h11, 8'h23, 8'hFF};
    for (int v = 0; v < 256; v++) rr[v] = 0;
    agent_pid = {8'h0A, 8'h07, 8'h04, 8'h01};
    repeat (3) @(negedge clk);
    chk("R11 reset mask", 32'(target_mask), 0);
    chk("R11 reset done", 32'(done), 0);
    chk("R11 reset rdata", cmd_lo_rdata, 0);
    chk("R11 reset dest", 32'(dest_q), 0);
    rst_n = 1;

    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 0) begin
        agent_lid = {8'h08, 8'h04, 8'h02, 8'h01}; agent_cluster = 4'b0000;
      end else begin
        agent_lid = {8'h22, 8'h21, 8'h12, 8'h11}; agent_cluster = 4'b1111;
      end
      for (int rd = 0; rd < 2; rd++) begin
        agent_ready = rd ? 4'b1011 : 4'b1111;
        for (int sh = 0; sh < 4; sh++)
          for (int lg = 0; lg < 2; lg++)
            for (int md = 0; md < 2; md++)
              for (int di = 0; di < 8; di++)
                for (int sn = 0; sn < 4; sn += 2) begin
                  logic [31:0] lo;
                  lo = {12'h0, 2'(sh), 5'h0, (sn == 2), 1'(lg), 3'(md), 8'(8'h40 + di)};
                  issue(rd ? "R8 ready" : tag_of(lo, agent_cluster), lo, dests[di], sn);
                end
      end
    end

    // R9: repeated lowest-priority on one vector rotates with wrap, skipping agent 2
    agent_lid = {8'h08, 8'h04, 8'h02, 8'h01}; agent_cluster = 4'b0000; agent_ready = 4'b1011;
    for (int r = 0; r < 6; r++) issue("R9 rotate", 32'h0008_0930, 8'h00, 1);
    // R10: empty bitmap leaves pointer as is, then next pick continues
    issue("R10 empty", 32'h0000_0930, 8'h04, 1);
    issue("R9 after empty", 32'h0000_0930, 8'h0B, 1);
    // R6: mixed formats in one table
    agent_lid = {8'h31, 8'h32, 8'h03, 8'h01}; agent_cluster = 4'b1100; agent_ready = 4'b1111;
    issue("R6 mixed", 32'h0000_0805, 8'h33, 0);
    issue("R5 mixed", 32'h0000_0805, 8'h01, 0);

    // R1: high-word write alone does not resolve or disturb the mask
    begin
      logic [N-1:0] held;
      held = target_mask;
      @(negedge clk); cmd_hi_wr = 1; cmd_hi_dest = 8'h99;
      @(negedge clk); cmd_hi_wr = 0;
      chk("R1 hi only done", 32'(done), 0);
      chk("R1 hi only mask", 32'(target_mask), 32'(held));
      chk("R3 hi only dest", 32'(dest_q), 32'h99);
    end
    wrap_up();
  end
endmodule